// File: doc/BRIEF.md
# Posted Write Store Buffer

This block sits between a processor's data port and a single-master memory bus of the cyc/stb/ack kind. The core hands over a store in one cycle. The block keeps the store's address, data and byte enables in an in-order queue and retires the queued stores to the bus one at a time. Each bus write takes at least two cycles. Because of the queue, a run of stores, such as a register save on function entry, goes at one per cycle until the queue is full, even though the bus is slower.

The core has two valid/ready streams. The store stream `st_*` carries back-pressure only through `st_ready`. `st_ready` is high whenever the queue has a free slot, and a store is taken in any cycle where `st_valid` and `st_ready` are both high. While `st_ready` is low, the core must hold `st_valid` and the store fields steady. The read stream `rd_*` carries loads and refills. A read request stays pending until all queued stores have reached the bus. It then goes out as a single bus read. `rd_ready` is high for exactly the one cycle in which the bus answers, and that same cycle carries `rd_data` and `rd_err`. The core holds `rd_valid` and the request fields until it sees `rd_ready`.

A queued write that ends with a bus error is dropped from the queue, and it sets a flag that only reset clears.

Top module: `posted_write_buffer`

## Requirements
- R1: After reset, `st_ready` is 1, `wb_cyc`, `wb_stb` and `wb_we` are 0, `rd_ready` is 0 and `err_flag` is 0.
- R2: While fewer than DEPTH stores are held, `st_ready` is 1, and a store presented with `st_valid` is taken in that same cycle without a stall.
- R3: Stores reach the bus in the order they were taken. During a queued write, `wb_cyc`, `wb_stb` and `wb_we` are 1, and `wb_adr`, `wb_dat_o` and `wb_sel` stay unchanged until `wb_ack` or `wb_err`. That answer removes the oldest entry.
- R4: The byte enables of a store reach `wb_sel` unchanged. Bit i of the enable covers data bits 8i+7 down to 8i, so a partial store changes only the enabled bytes of the target word.
- R5: A read is started on the bus (`wb_cyc`=1, `wb_we`=0) only when no store is held. Every store taken before the read request has been answered by the bus before the read completes.
- R6: With DEPTH stores held, `st_ready` is 0 and no further store is taken.
- R7: A store held on the port while `st_ready` is 0 is taken once a slot frees. It then reaches the bus with its own address, data and enables.
- R8: A queued write answered with `wb_err` is discarded and sets `err_flag`. `err_flag` stays 1 until reset, and later stores still drain normally.
- R9: `rd_ready` is 1 only in the cycle a bus read receives `wb_ack` or `wb_err`. In that cycle `rd_data` equals `wb_dat_i`, and `rd_err` is 1 exactly when the answer was `wb_err`.
- R10: After each bus answer, `wb_cyc` is 0 for at least one cycle, so every bus transaction lasts two or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store offered by the core |
| st_ready | output | 1 | Queue has a free slot; store taken when both high |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_sel | input | DATA_W/8 | Store byte enables |
| rd_valid | input | 1 | Read (load or refill) requested |
| rd_ready | output | 1 | Read answered this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| rd_sel | input | DATA_W/8 | Read byte enables |
| rd_data | output | DATA_W | Read data, valid with rd_ready |
| rd_err | output | 1 | Read ended in bus error, valid with rd_ready |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | ADDR_W | Bus address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_sel | output | DATA_W/8 | Bus byte enables |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_ack | input | 1 | Bus normal answer |
| wb_err | input | 1 | Bus error answer |
| err_flag | output | 1 | Sticky write-error flag |

## Verification
The bench uses the default build: DEPTH of 16, with 32-bit address and data and therefore four byte enables. At this depth the full boundary takes only sixteen stores queued behind a stalled bus, and the seventeenth store is the one that sees back-pressure. The 32-bit data width gives four independent byte lanes, so overlapping partial stores to one word show whether each lane merges correctly when the word is read back.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_WRITE = 2'd1,
    BS_READ  = 2'd2
  } bus_state_e;

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] slot [DEPTH];

  // one register per slot, loaded when the write pointer selects it
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PTR_W'(g))) slot[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = slot[rd_ptr];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/pwb_bus_master.sv
module pwb_bus_master
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DATA_W-1:0] q_data,
  input  logic [SEL_W-1:0]  q_sel,
  output logic              q_pop,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output logic              wr_fault,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack,
  input  logic              wb_err
);
  bus_state_e        state_q, state_d;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [SEL_W-1:0]  rd_sel_q;
  logic              answered;

  assign answered = wb_ack || wb_err;

  // queued writes always win over a waiting read
  always_comb begin
    state_d = state_q;
    case (state_q)
      BS_IDLE: begin
        if (!q_empty)      state_d = BS_WRITE;
        else if (rd_valid) state_d = BS_READ;
      end
      BS_WRITE, BS_READ: begin
        if (answered) state_d = BS_IDLE;
      end
      default: state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= BS_IDLE;
      rd_addr_q <= '0;
      rd_sel_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == BS_IDLE && state_d == BS_READ) begin
        rd_addr_q <= rd_addr;
        rd_sel_q  <= rd_sel;
      end
    end
  end

  assign wb_cyc   = (state_q != BS_IDLE);
  assign wb_stb   = (state_q != BS_IDLE);
  assign wb_we    = (state_q == BS_WRITE);
  assign wb_adr   = wb_we ? q_addr : rd_addr_q;
  assign wb_dat_o = wb_we ? q_data : '0;
  assign wb_sel   = wb_we ? q_sel  : rd_sel_q;

  assign q_pop    = wb_we && answered;
  assign wr_fault = wb_we && wb_err;
  assign rd_ready = (state_q == BS_READ) && answered;
  assign rd_data  = wb_dat_i;
  assign rd_err   = (state_q == BS_READ) && wb_err;

endmodule

// File: rtl/pwb_sticky.sv
module pwb_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [DATA_W/8-1:0]   st_sel,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [DATA_W/8-1:0]   rd_sel,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_err,
  output logic                  wb_cyc,
  output logic                  wb_stb,
  output logic                  wb_we,
  output logic [ADDR_W-1:0]     wb_adr,
  output logic [DATA_W-1:0]     wb_dat_o,
  output logic [DATA_W/8-1:0]   wb_sel,
  input  logic [DATA_W-1:0]     wb_dat_i,
  input  logic                  wb_ack,
  input  logic                  wb_err,
  output logic                  err_flag
);
  localparam int SEL_W   = DATA_W / 8;
  localparam int ENTRY_W = ADDR_W + DATA_W + SEL_W;
  localparam int CNT_W   = $clog2(DEPTH+1);

  logic               st_fire;
  logic               fifo_full, fifo_empty, fifo_pop, wr_fault;
  logic [CNT_W-1:0]   fifo_count;
  logic [ENTRY_W-1:0] head;
  logic [ADDR_W-1:0]  head_addr;
  logic [DATA_W-1:0]  head_data;
  logic [SEL_W-1:0]   head_sel;

  assign st_ready = !fifo_full;
  assign st_fire  = st_valid && st_ready;
  assign {head_addr, head_data, head_sel} = head;

  pwb_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_fire),
    .push_data ({st_addr, st_data, st_sel}),
    .pop       (fifo_pop),
    .head      (head),
    .count     (fifo_count),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  pwb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_empty  (fifo_empty),
    .q_addr   (head_addr),
    .q_data   (head_data),
    .q_sel    (head_sel),
    .q_pop    (fifo_pop),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_sel   (rd_sel),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .wr_fault (wr_fault),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_sel   (wb_sel),
    .wb_dat_i (wb_dat_i),
    .wb_ack   (wb_ack),
    .wb_err   (wb_err)
  );

  pwb_sticky u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wr_fault),
    .flag  (err_flag)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       st_valid,
  input logic                       st_ready,
  input logic                       wb_cyc,
  input logic                       wb_stb,
  input logic                       wb_we,
  input logic [ADDR_W-1:0]          wb_adr,
  input logic [DATA_W-1:0]          wb_dat_o,
  input logic [DATA_W/8-1:0]        wb_sel,
  input logic                       wb_ack,
  input logic                       wb_err,
  input logic                       err_flag,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       fifo_empty
);
  localparam int CNT_W = $clog2(DEPTH+1);

  p_ready_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count < CNT_W'(DEPTH)) |-> st_ready);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(DEPTH)) |-> !st_ready);

  p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && wb_we && !wb_ack && !wb_err) |=>
      (wb_cyc && wb_stb && wb_we && $stable(wb_adr) && $stable(wb_dat_o) && $stable(wb_sel)));

  p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_we && (wb_ack || wb_err)) |=>
      (fifo_count + CNT_W'(1) == $past(fifo_count) + CNT_W'($past(st_valid && st_ready))));

  p_read_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_we && !$past(wb_cyc)) |-> $past(fifo_empty));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_gap_after_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && (wb_ack || wb_err)) |=> !wb_cyc);

endmodule

bind posted_write_buffer pwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_pwb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .wb_cyc     (wb_cyc),
  .wb_stb     (wb_stb),
  .wb_we      (wb_we),
  .wb_adr     (wb_adr),
  .wb_dat_o   (wb_dat_o),
  .wb_sel     (wb_sel),
  .wb_ack     (wb_ack),
  .wb_err     (wb_err),
  .err_flag   (err_flag),
  .fifo_count (fifo_count),
  .fifo_empty (fifo_empty)
);

// File: tb/tb_posted_write_buffer.sv
`timescale 1ns/1ps
module tb_posted_write_buffer;
  localparam logic [31:0] ERR_ADDR = 32'h0000_0100;
  localparam int NV = 8;
  // {addr, data, sel}
  localparam logic [67:0] VEC [NV] = '{
    {32'h00, 32'h1122_3344, 4'hF},
    {32'h04, 32'hAABB_CCDD, 4'hF},
    {32'h00, 32'h0000_00EE, 4'h1},
    {32'h08, 32'h5566_7788, 4'hF},
    {32'h04, 32'h9900_0000, 4'h8},
    {32'h0C, 32'h0F0F_0F0F, 4'h6},
    {32'h08, 32'h1234_0000, 4'hC},
    {32'h10, 32'hCAFE_F00D, 4'hF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_sel = '0;
  logic rd_valid = 1'b0, rd_ready, rd_err;
  logic [31:0] rd_addr = '0, rd_data;
  logic [3:0]  rd_sel = 4'hF;
  logic wb_cyc, wb_stb, wb_we, wb_ack, wb_err, err_flag;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i;
  logic [3:0]  wb_sel;

  always #2.5 clk = ~clk;

  posted_write_buffer dut (.*);

  // bus slave model
  logic        hold = 1'b0;
  logic [31:0] smem [16];
  logic [67:0] wlog [64];
  int          wlog_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack <= 1'b0; wb_err <= 1'b0; wb_dat_i <= '0; wlog_n <= 0;
      for (int i = 0; i < 16; i++) smem[i] <= '0;
    end else begin
      wb_ack <= 1'b0; wb_err <= 1'b0;
      if (wb_cyc && wb_we && wb_ack) begin
        wlog[wlog_n] <= {wb_adr, wb_dat_o, wb_sel};
        wlog_n <= wlog_n + 1;
      end
      if (wb_cyc && wb_stb && !wb_ack && !wb_err && !hold) begin
        if (wb_adr == ERR_ADDR) wb_err <= 1'b1;
        else begin
          wb_ack <= 1'b1;
          if (wb_we) begin
            for (int b = 0; b < 4; b++)
              if (wb_sel[b]) smem[wb_adr[5:2]][8*b +: 8] <= wb_dat_o[8*b +: 8];
          end else wb_dat_i <= smem[wb_adr[5:2]];
        end
      end
    end
  end

  int total = 0, bad = 0, n_good = 0, r10_bad = 0, cyc_cnt = 0;
  logic [31:0] exp_mem [16];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && prev_done && wb_cyc) r10_bad++;
    prev_done = wb_cyc && (wb_ack || wb_err);
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc_cnt, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    if (a != ERR_ADDR) begin
      n_good++;
      for (int b = 0; b < 4; b++)
        if (s[b]) exp_mem[a[5:2]][8*b +: 8] = d[8*b +: 8];
    end
  endfunction

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, output int stalls);
    stalls = 0;
    st_valid = 1'b1; st_addr = a; st_data = d; st_sel = s;
    while (!st_ready) begin @(negedge clk); stalls++; end
    @(negedge clk);
    st_valid = 1'b0;
    model_write(a, d, s);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic e, output int logged);
    rd_valid = 1'b1; rd_addr = a;
    forever begin
      @(negedge clk);
      if (rd_ready) break;
    end
    d = rd_data; e = rd_err; logged = wlog_n;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    int st;
    int lg;
    logic [31:0] d;
    logic e;
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(st_ready == 1'b1, "R1 st_ready", 68'(st_ready), 68'd1);
    chk(!wb_cyc && !wb_stb && !wb_we, "R1 bus idle", 68'({wb_cyc, wb_stb, wb_we}), 68'd0);
    chk(rd_ready == 1'b0, "R1 rd_ready", 68'(rd_ready), 68'd0);
    chk(err_flag == 1'b0, "R1 err_flag", 68'(err_flag), 68'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: back-to-back stores, no stalls (R2)
    for (int i = 0; i < NV; i++) begin
      store(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0], st);
      chk(st == 0, "R2 store stall", 68'(st), 68'd0);
    end
    // read right away: must wait for queue to drain (R5), merge per byte lane (R4)
    for (int i = 0; i < 5; i++) begin
      do_read(32'(i * 4), d, e, lg);
      if (i == 0) chk(lg == n_good, "R5 writes before read", 68'(lg), 68'(n_good));
      chk(d == exp_mem[i], "R4 merged word", 68'(d), 68'(exp_mem[i]));
      chk(e == 1'b0, "R9 rd_err clear", 68'(e), 68'd0);
    end
    // bus order and values (R3, R4)
    for (int i = 0; i < NV; i++)
      chk(wlog[i] == VEC[i], "R3 write order", wlog[i], VEC[i]);

    // fill to DEPTH behind a stalled bus (R6), then a held store (R7)
    hold = 1'b1;
    for (int i = 0; i < 16; i++) begin
      store(32'(i * 4), 32'hD000_0000 + 32'(i), 4'hF, st);
      chk(st == 0, "R2 fill stall", 68'(st), 68'd0);
    end
    st_valid = 1'b1; st_addr = 32'h40; st_data = 32'hBEEF_0017; st_sel = 4'hF;
    for (int k = 0; k < 4; k++) begin
      chk(st_ready == 1'b0, "R6 full back-pressure", 68'(st_ready), 68'd0);
      @(negedge clk);
    end
    hold = 1'b0;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    model_write(32'h40, 32'hBEEF_0017, 4'hF);
    do_read(32'h40, d, e, lg);
    chk(d == 32'hBEEF_0017, "R7 held store data", 68'(d), 68'h0BEEF0017);
    chk(lg == NV + 17, "R7 write count", 68'(lg), 68'(NV + 17));
    chk(wlog[NV + 16] == {32'h40, 32'hBEEF_0017, 4'hF}, "R7 held store on bus",
        wlog[NV + 16], {32'h40, 32'hBEEF_0017, 4'hF});
    chk(wlog[NV] == {32'h0, 32'hD000_0000, 4'hF}, "R3 fill order first",
        wlog[NV], {32'h0, 32'hD000_0000, 4'hF});

    // write error: entry discarded, sticky flag (R8)
    chk(err_flag == 1'b0, "R8 flag before", 68'(err_flag), 68'd0);
    store(ERR_ADDR, 32'hDEAD_DEAD, 4'hF, st);
    store(32'h44, 32'h600D_D00D, 4'hF, st);
    do_read(32'h44, d, e, lg);
    chk(d == 32'h600D_D00D, "R8 later store drains", 68'(d), 68'h0600DD00D);
    chk(err_flag == 1'b1, "R8 flag set", 68'(err_flag), 68'd1);
    chk(lg == n_good, "R8 faulted entry not acked", 68'(lg), 68'(n_good));
    store(32'h48, 32'h0000_5A5A, 4'h3, st);
    do_read(32'h48, d, e, lg);
    chk(d == exp_mem[2], "R4 partial after error", 68'(d), 68'(exp_mem[2]));
    chk(err_flag == 1'b1, "R8 flag sticky", 68'(err_flag), 68'd1);

    // read error (R9)
    do_read(ERR_ADDR, d, e, lg);
    chk(e == 1'b1, "R9 rd_err on bus error", 68'(e), 68'd1);

    repeat (3) @(negedge clk);
    chk(r10_bad == 0, "R10 idle gap", 68'(r10_bad), 68'd0);
    chk(!wb_cyc, "R10 bus idle at end", 68'(wb_cyc), 68'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule